// File: doc/BRIEF.md
# SPI Delay-After-Transfer Timer

This block measures out the idle gap that an SPI master leaves between the end of one frame and the next chip-select assertion. The frame controller pulses a start input when a frame finishes. The block then counts system clocks until the programmed gap has gone by, and announces the end with a one-cycle done pulse. A busy flag stays high for the whole gap.

The gap length comes from two small codes taken from the transfer-attribute set chosen for the current frame. The prescale code picks an odd divider of 1, 3, 5 or 7. The scale code picks a power of two. The gap in system clocks is the product of the two. At a 64 MHz clock this covers 31.25 ns (divider 1, scaler 2) up to about 7.17 ms (divider 7, scaler 65536).

The counting is split in two parts. A prescale counter gives one tick every divider clocks, and a scale counter counts those ticks up to the scaler value. Both codes are captured when start is accepted, so a rewrite of the attribute set during a gap does not change that gap. A synchronous abort ends a gap early without a done pulse.

The control state machine has two states:
- IDLE: no gap is running.
- COUNT: a gap is running.

It has three transitions:
- ARM (IDLE to COUNT) on an accepted start.
- EXPIRE (COUNT to IDLE) when the last tick arrives. This transition raises done.
- CANCEL (COUNT to IDLE) on abort. This transition gives no done.

Top module: `xfer_gap_timer`

## Requirements
- R1: The prescale code `pre_code_i` selects the divider 2*code+1: code 0 gives 1, code 1 gives 3, code 2 gives 5 and code 3 gives 7.
- R2: The scale code `scl_code_i` with value n selects the scaler 2^(n+1). With the default 4-bit code this is 2 for code 0 and 65536 for code 15.
- R3: If start is sampled high while idle at clock edge E0, `done_o` is high in the cycle that follows edge E(N), where N = divider * scaler.
- R4: `busy_o` goes high in the cycle after an accepted start. It stays high until the cycle in which done is raised, or until an abort. It stays low while idle with no start.
- R5: `done_o` is high for exactly one cycle. `busy_o` is low in that same cycle, having been high in the cycle before.
- R6: Both codes are captured at the accepting edge. Changing them during a gap has no effect on that gap's length.
- R7: A start that is sampled while busy is ignored. This includes a start sampled at the very edge where done is raised: it neither restarts nor lengthens the gap, and busy does not rise again afterwards.
- R8: When `abort_i` is sampled high while busy, busy is cleared and no done is produced, even at the edge where done would have been raised. When start and abort are sampled together while idle, no gap starts. After an abort, a new start gives a full gap.
- R9: During reset and right after it is released, `busy_o` and `done_o` are low.
- R10: The width SCL_W of the scale code is a parameter. The scaler range is 2 up to 2^(2^SCL_W), and R2 applies across all 2^SCL_W codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame-ended pulse from the frame controller |
| abort_i | input | 1 | Synchronous cancel of a running gap |
| pre_code_i | input | PRE_W | Prescale divider code |
| scl_code_i | input | SCL_W | Power-of-two scaler code |
| busy_o | output | 1 | Gap in progress |
| done_o | output | 1 | One-cycle pulse at the end of the gap |

## Verification
The bench builds two instances side by side.

The first uses the defaults (PRE_W=2, SCL_W=4). Its full code sweep would need millions of clocks, so the bench covers the following:
- every divider with the scale codes 0 to 9;
- a single divider-7, scaler-16384 gap of 114688 clocks;
- the code-hold, restart and abort corner cases.

The second is built with SCL_W=2, which shrinks the whole code space to 16 combinations of a few hundred clocks in total. Every divider and scaler pairing can then be timed from start to done and compared with the product.

// File: rtl/xgt_pkg.sv
package xgt_pkg;

    // Control states of the gap timer
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_COUNT = 1'b1
    } xgt_state_e;

    // Divider value for a prescale code: 2*code+1
    function automatic int unsigned pre_divider(input int unsigned code);
        return 2 * code + 1;
    endfunction

endpackage

// File: rtl/xgt_code_hold.sv
module xgt_code_hold #(
    parameter int PRE_W = 2,
    parameter int SCL_W = 4,
    localparam int SCL_SPAN = 2 ** SCL_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [PRE_W-1:0]    pre_code_i,
    input  logic [SCL_W-1:0]    scl_code_i,
    output logic [PRE_W:0]      pre_lim_o,
    output logic [SCL_SPAN-1:0] scl_lim_o
);

    logic [PRE_W-1:0] pre_q;
    logic [SCL_W-1:0] scl_q;

    // Codes are captured only when a gap is armed
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            scl_q <= '0;
        end else if (load_i) begin
            pre_q <= pre_code_i;
            scl_q <= scl_code_i;
        end
    end

    // Divider 2c+1 counts 0..2c, so its terminal value is 2c
    assign pre_lim_o = {pre_q, 1'b0};

    // Scaler 2^(c+1) counts 0..2^(c+1)-1: bits 0..c set (thermometer)
    for (genvar i = 0; i < SCL_SPAN; i++) begin : g_therm
        localparam logic [SCL_W:0] BIT_IDX = (SCL_W + 1)'(i);
        assign scl_lim_o[i] = ({1'b0, scl_q} >= BIT_IDX);
    end

endmodule

// File: rtl/xgt_prescale.sv
module xgt_prescale #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic [CNT_W-1:0] lim_i,
    output logic             tick_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             at_lim;

    assign at_lim = (cnt_q == lim_i);
    assign tick_o = en_i && at_lim;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (en_i) begin
            if (at_lim) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/xgt_scale.sv
module xgt_scale #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] lim_i,
    output logic             last_o
);

    logic [CNT_W-1:0] cnt_q;

    // Last tick of the gap: the tick that would take the count past its limit
    assign last_o = tick_i && (cnt_q == lim_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/xgt_fsm.sv
module xgt_fsm
    import xgt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic abort_i,
    input  logic last_i,
    output logic load_o,
    output logic clr_o,
    output logic run_o,
    output logic busy_o,
    output logic done_o
);

    xgt_state_e state_q;
    xgt_state_e state_nxt;
    logic       arm;
    logic       cancel;
    logic       expire;

    // Transition conditions: ARM, CANCEL (abort wins), EXPIRE
    assign arm    = (state_q == ST_IDLE) && start_i && !abort_i;
    assign cancel = (state_q == ST_COUNT) && abort_i;
    assign expire = (state_q == ST_COUNT) && !abort_i && last_i;

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (arm) begin
                    state_nxt = ST_COUNT;
                end
            end
            ST_COUNT: begin
                if (cancel || expire) begin
                    state_nxt = ST_IDLE;
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nxt;
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            done_o <= 1'b0;
        end else begin
            busy_o <= (state_nxt == ST_COUNT);
            done_o <= expire;
        end
    end

    // Datapath controls
    assign load_o = arm;
    assign clr_o  = arm || cancel;
    assign run_o  = (state_q == ST_COUNT) && !abort_i;

endmodule

// File: rtl/xfer_gap_timer.sv
module xfer_gap_timer #(
    parameter int PRE_W = 2,
    parameter int SCL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             abort_i,
    input  logic [PRE_W-1:0] pre_code_i,
    input  logic [SCL_W-1:0] scl_code_i,
    output logic             busy_o,
    output logic             done_o
);

    localparam int PRE_CNT_W = PRE_W + 1;
    localparam int SCL_CNT_W = 2 ** SCL_W;

    logic                 load;
    logic                 clr;
    logic                 run;
    logic                 tick;
    logic                 last;
    logic [PRE_CNT_W-1:0] pre_lim;
    logic [SCL_CNT_W-1:0] scl_lim;

    xgt_code_hold #(
        .PRE_W(PRE_W),
        .SCL_W(SCL_W)
    ) u_code_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .pre_code_i(pre_code_i),
        .scl_code_i(scl_code_i),
        .pre_lim_o (pre_lim),
        .scl_lim_o (scl_lim)
    );

    xgt_prescale #(
        .CNT_W(PRE_CNT_W)
    ) u_prescale (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr),
        .en_i  (run),
        .lim_i (pre_lim),
        .tick_o(tick)
    );

    xgt_scale #(
        .CNT_W(SCL_CNT_W)
    ) u_scale (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr),
        .tick_i(tick),
        .lim_i (scl_lim),
        .last_o(last)
    );

    xgt_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start_i),
        .abort_i(abort_i),
        .last_i (last),
        .load_o (load),
        .clr_o  (clr),
        .run_o  (run),
        .busy_o (busy_o),
        .done_o (done_o)
    );

endmodule

// File: rtl/xfer_gap_timer_chk.sv
module xfer_gap_timer_chk #(
    parameter int PRE_W = 2,
    parameter int SCL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             abort_i,
    input logic [PRE_W-1:0] pre_code_i,
    input logic [SCL_W-1:0] scl_code_i,
    input logic             busy_o,
    input logic             done_o
);

    localparam int LEN_W = PRE_W + 1 + (2 ** SCL_W) + 1;

    logic             accept;
    logic [SCL_W:0]   shamt;
    logic [LEN_W-1:0] run_len;
    logic [LEN_W-1:0] run_cnt;

    assign accept = !busy_o && start_i && !abort_i;
    assign shamt  = {1'b0, scl_code_i} + {{SCL_W{1'b0}}, 1'b1};

    // Independent gap model: expected length and elapsed edges
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= '0;
            run_cnt <= '0;
        end else if (accept) begin
            run_len <= LEN_W'({pre_code_i, 1'b1}) << shamt;
            run_cnt <= '0;
        end else if (busy_o) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    AST_ARM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy_o); // R4
    AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !abort_i) |=> (busy_o || done_o)); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> (!busy_o && !done_o)); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R5
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o))); // R5
    AST_GAP_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (run_cnt == run_len)); // R3
    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (run_cnt < run_len)); // R7
    AST_CANCEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && abort_i) |=> (!busy_o && !done_o)); // R8

endmodule

bind xfer_gap_timer xfer_gap_timer_chk #(
    .PRE_W(PRE_W),
    .SCL_W(SCL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .abort_i   (abort_i),
    .pre_code_i(pre_code_i),
    .scl_code_i(scl_code_i),
    .busy_o    (busy_o),
    .done_o    (done_o)
);

// File: tb/test_xfer_gap_timer.sv
module test_xfer_gap_timer;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 195000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_w = 1'b0, abort_w = 1'b0;
    logic       start_n = 1'b0, abort_n = 1'b0;
    logic [1:0] pre_code = '0;
    logic [3:0] scl_code = '0;
    logic       busy_w, done_w, busy_n, done_n;
    int         total = 0;
    int         bad = 0;
    bit         finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    xfer_gap_timer i_xfer_gap_timer (
        .clk(clk), .rst_n(rst_n), .start_i(start_w), .abort_i(abort_w),
        .pre_code_i(pre_code), .scl_code_i(scl_code),
        .busy_o(busy_w), .done_o(done_w)
    );

    xfer_gap_timer #(.PRE_W(2), .SCL_W(2)) i_xfer_gap_timer_nar (
        .clk(clk), .rst_n(rst_n), .start_i(start_n), .abort_i(abort_n),
        .pre_code_i(pre_code), .scl_code_i(scl_code[1:0]),
        .busy_o(busy_n), .done_o(done_n)
    );

    function automatic int gap_len(input int p, input int s);
        return (2 * p + 1) * (1 << (s + 1));
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic set_start(input bit nar, input logic v);
        if (nar) start_n = v; else start_w = v;
    endtask

    task automatic set_abort(input bit nar, input logic v);
        if (nar) abort_n = v; else abort_w = v;
    endtask

    function automatic int get_busy(input bit nar);
        return nar ? int'(busy_n) : int'(busy_w);
    endfunction

    function automatic int get_done(input bit nar);
        return nar ? int'(done_n) : int'(done_w);
    endfunction

    // mode 0 plain, 1 codes changed mid-gap, 2 start mid-gap, 3 start at done edge
    task automatic timed_run(input bit nar, input int p, input int s, input int mode,
                             input string req);
        int exp;
        int n;
        exp = gap_len(p, s);
        @(negedge clk);
        pre_code = p[1:0];
        scl_code = s[3:0];
        set_start(nar, 1'b1);
        @(negedge clk);
        set_start(nar, 1'b0);
        if (mode == 1) begin
            pre_code = ~pre_code;
            scl_code = ~scl_code;
        end
        check("R4", "busy after start", get_busy(nar), 1);
        n = 0;
        while (get_done(nar) == 0 && n < exp + 20) begin
            if (mode == 2 && n == 3) set_start(nar, 1'b1);
            if (mode == 2 && n == 4) set_start(nar, 1'b0);
            if (mode == 3 && n == exp - 1) set_start(nar, 1'b1);
            @(negedge clk);
            n++;
        end
        set_start(nar, 1'b0);
        check(req, $sformatf("clocks start->done p=%0d s=%0d", p, s), n, exp);
        check("R5", "busy in done cycle", get_busy(nar), 0);
        @(negedge clk);
        check("R5", "done one cycle wide", get_done(nar), 0);
        if (mode == 3) check("R7", "busy after start at done edge", get_busy(nar), 0);
    endtask

    task automatic reset_test();
        check("R9", "busy in reset", int'(busy_w) + int'(busy_n), 0);
        check("R9", "done in reset", int'(done_w) + int'(done_n), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", "busy after reset", int'(busy_w) + int'(busy_n), 0);
        check("R9", "done after reset", int'(done_w) + int'(done_n), 0);
    endtask

    task automatic sweep_wide();
        // R1 divider codes, R2 scaler codes, R3 product timing
        for (int p = 0; p < 4; p++) begin
            for (int s = 0; s < 10; s++) begin
                timed_run(1'b0, p, s, 0, "R3");
            end
        end
    endtask

    task automatic sweep_narrow();
        // R10: every pairing of the 2-bit scale code, R1 for each divider
        for (int p = 0; p < 4; p++) begin
            for (int s = 0; s < 4; s++) begin
                timed_run(1'b1, p, s, 0, "R10");
            end
        end
    endtask

    task automatic long_gap();
        timed_run(1'b0, 3, 13, 0, "R2");
        timed_run(1'b0, 1, 0, 0, "R1");
    endtask

    task automatic code_hold();
        timed_run(1'b0, 1, 3, 1, "R6");
    endtask

    task automatic restart_ignored();
        timed_run(1'b0, 2, 2, 2, "R7");
        timed_run(1'b0, 0, 1, 3, "R7");
    endtask

    task automatic abort_cases();
        int seen;
        // cancel mid-gap
        @(negedge clk);
        pre_code = 2'd0;
        scl_code = 4'd5;
        start_w = 1'b1;
        @(negedge clk);
        start_w = 1'b0;
        repeat (10) @(negedge clk);
        abort_w = 1'b1;
        @(negedge clk);
        abort_w = 1'b0;
        check("R8", "busy after abort", int'(busy_w), 0);
        seen = 0;
        repeat (100) begin
            @(negedge clk);
            seen += int'(done_w) + int'(busy_w);
        end
        check("R8", "done/busy after abort", seen, 0);
        // start and abort together while idle
        start_w = 1'b1;
        abort_w = 1'b1;
        @(negedge clk);
        start_w = 1'b0;
        abort_w = 1'b0;
        check("R8", "busy after start with abort", int'(busy_w), 0);
        // abort at the edge where done would rise (gap of 2)
        pre_code = 2'd0;
        scl_code = 4'd0;
        start_w = 1'b1;
        @(negedge clk);
        start_w = 1'b0;
        @(negedge clk);
        abort_w = 1'b1;
        @(negedge clk);
        abort_w = 1'b0;
        check("R8", "done with abort at final edge", int'(done_w), 0);
        check("R8", "busy with abort at final edge", int'(busy_w), 0);
        seen = 0;
        repeat (5) begin
            @(negedge clk);
            seen += int'(done_w);
        end
        check("R8", "late done after abort", seen, 0);
        // full gap after abort
        timed_run(1'b0, 0, 2, 0, "R8");
    endtask

    initial begin
        reset_test();
        sweep_narrow();
        sweep_wide();
        code_hold();
        restart_ignored();
        abort_cases();
        long_gap();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R3 watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule